// File: doc/BRIEF.md
# DRAM Parallel Test Mode Controller

This block sits on the device side of a multiplexed-address DRAM interface. It samples the row strobe, column strobe and write-enable pins on a fast system clock and sorts every row-strobe cycle into one of three kinds. A row-strobe fall with the column strobe still high is a row cycle. A fall with the column strobe low and write-enable high is a column-before-row refresh. A fall with both the column strobe and write-enable low is a write-and-column-before-row cycle. From these kinds it enters and leaves a compressed parallel test mode. While test mode is active, a write copies each data bit into the four cells that share the upper column address. A read compares those four cells and returns one pass/fail bit for each I/O line.

Cell storage is outside the block, in a behavioural array model. The block reaches it through a group-wide request port that uses valid/ready. A request stays in its holding register with every field unchanged until the array raises ready, so the array applies back-pressure by holding ready low. The request port holds one request at a time. A column access that arrives while a request is still waiting is dropped, so the array must accept each request before the next column-strobe fall. The array returns read data on a response strobe that has no back-pressure. The block turns that data into a read result, pulsed on `rd_valid` for one cycle. Test-mode reads take a fixed number of extra cycles.

Top module: `ptm_ctrl`

## Requirements
- R1: After reset, `test_mode` is 0, `cycle_kind` is 0, and `arr_req_valid` and `rd_valid` are 0.
- R2: A row-strobe fall sampled while `cas_n` and `we_n` are both low sets `test_mode` to 1.
- R3: A row-strobe fall sampled while `cas_n` is low and `we_n` is high clears `test_mode`.
- R4: A row cycle in which the row strobe rises again with no column-strobe fall clears `test_mode`. A row cycle that contains a column access leaves the mode unchanged.
- R5: In test mode, both a further write-and-column-before-row cycle and a normal read cycle leave `test_mode` at 1.
- R6: Outside test mode, a write asserts exactly one bit of `arr_req_wmask`, bit `col[1:0]`. Only that cell of the four-cell group changes.
- R7: In test mode, a write sets all four `arr_req_wmask` bits and places `dq_in` in every four-bit slot of `arr_req_wdata`. Slot k occupies bits [4k+3:4k] for IO_W=4.
- R8: Outside test mode, a read returns slot `col[1:0]` of the addressed group on `rd_data`.
- R9: In test mode, bit i of `rd_data` is 1 when bit i of all four slots is equal, and 0 otherwise. The value is independent of `col[1:0]`.
- R10: `rd_valid` pulses for one cycle, 1 cycle after `arr_rsp_valid` for a normal read and 1+TM_EXTRA cycles after it for a test-mode read.
- R11: While `arr_req_valid` is 1 and `arr_req_ready` is 0, the request stays valid and its address, mask and write flag stay stable.
- R12: `cycle_kind` gives the kind of the most recent row-strobe fall: 1 for row, 2 for column-before-row, 3 for write-and-column-before-row.
- R13: The array group address `arr_req_addr` is the latched row followed by `col[ADDR_W-1:2]`. Column bits 1:0 never reach the array address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ras_n | input | 1 | Row strobe, active low |
| cas_n | input | 1 | Column strobe, active low |
| we_n | input | 1 | Write enable, active low |
| addr | input | ADDR_W | Multiplexed row/column address |
| dq_in | input | IO_W | Write data |
| rd_valid | output | 1 | One-cycle read-result strobe |
| rd_data | output | IO_W | Read data or per-line pass/fail |
| test_mode | output | 1 | Parallel test mode active |
| cycle_kind | output | 2 | Kind of the last row-strobe fall |
| arr_req_valid | output | 1 | Array request valid |
| arr_req_ready | input | 1 | Array accepts request |
| arr_req_we | output | 1 | Request is a write |
| arr_req_addr | output | 2*ADDR_W-2 | Four-cell group address |
| arr_req_wmask | output | 4 | Per-slot write enables |
| arr_req_wdata | output | 4*IO_W | Write data, one slot per cell |
| arr_rsp_valid | input | 1 | Array read data valid |
| arr_rsp_data | input | 4*IO_W | All four cells of the group |

## Verification
The strobes pass through two sampling registers, so mode and kind changes appear on the second rising edge after a pin changes. The bench waits at least three cycles after each strobe change before it samples, always on the falling clock edge. Read results are due one cycle after the array response, or 1+TM_EXTRA cycles after it in test mode. The bench counts falling edges from the response it drives to the `rd_valid` pulse and compares that count exactly. Back-pressure holds are checked while ready is held low for several cycles.

// File: rtl/ptm_pkg.sv
package ptm_pkg;
  typedef enum logic [1:0] {
    KIND_NONE = 2'd0,
    KIND_ROW  = 2'd1,
    KIND_CBR  = 2'd2,
    KIND_WCBR = 2'd3
  } cyc_kind_e;

  localparam int SLOT_W = 2;
  localparam int SLOTS  = 1 << SLOT_W;
endpackage

// File: rtl/ptm_strobe_sync.sv
module ptm_strobe_sync #(
  parameter int ADDR_W = 11,
  parameter int IO_W   = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ras_n,
  input  logic              cas_n,
  input  logic              we_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic [IO_W-1:0]   dq_in,
  output logic              s_ras_n,
  output logic              s_cas_n,
  output logic              s_we_n,
  output logic [ADDR_W-1:0] s_addr,
  output logic [IO_W-1:0]   s_dq,
  output logic              ev_ras_fall,
  output logic              ev_ras_rise,
  output logic              ev_cas_fall
);
  logic d_ras_n, d_cas_n;

  // first stage: capture pins; second stage: previous strobe levels
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      s_ras_n <= 1'b1;
      s_cas_n <= 1'b1;
      s_we_n  <= 1'b1;
      s_addr  <= '0;
      s_dq    <= '0;
      d_ras_n <= 1'b1;
      d_cas_n <= 1'b1;
    end else begin
      s_ras_n <= ras_n;
      s_cas_n <= cas_n;
      s_we_n  <= we_n;
      s_addr  <= addr;
      s_dq    <= dq_in;
      d_ras_n <= s_ras_n;
      d_cas_n <= s_cas_n;
    end
  end

  assign ev_ras_fall = d_ras_n & ~s_ras_n;
  assign ev_ras_rise = ~d_ras_n & s_ras_n;
  assign ev_cas_fall = d_cas_n & ~s_cas_n;
endmodule

// File: rtl/ptm_mode_fsm.sv
module ptm_mode_fsm
  import ptm_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      ev_ras_fall,
  input  logic      ev_ras_rise,
  input  logic      ev_cas_fall,
  input  logic      s_ras_n,
  input  logic      s_cas_n,
  input  logic      s_we_n,
  output logic      test_mode,
  output cyc_kind_e kind,
  output logic      col_go
);
  logic in_row;
  logic col_seen;

  // a column access counts only inside a row cycle while the row strobe is low
  assign col_go = ev_cas_fall & in_row & ~s_ras_n;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      test_mode <= 1'b0;
      kind      <= KIND_NONE;
      in_row    <= 1'b0;
      col_seen  <= 1'b0;
    end else begin
      if (ev_ras_fall) begin
        if (s_cas_n) begin
          kind     <= KIND_ROW;
          in_row   <= 1'b1;
          col_seen <= 1'b0;
        end else if (s_we_n) begin
          kind      <= KIND_CBR;
          in_row    <= 1'b0;
          test_mode <= 1'b0;
        end else begin
          kind      <= KIND_WCBR;
          in_row    <= 1'b0;
          test_mode <= 1'b1;
        end
      end else if (ev_ras_rise) begin
        // row cycle with no column access is a row-only refresh
        if (in_row && !col_seen) begin
          test_mode <= 1'b0;
        end
        in_row <= 1'b0;
      end else if (col_go) begin
        col_seen <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/ptm_access.sv
module ptm_access
  import ptm_pkg::*;
#(
  parameter int ADDR_W = 11,
  parameter int IO_W   = 4,
  localparam int GA_W  = 2 * ADDR_W - SLOT_W,
  localparam int WD_W  = SLOTS * IO_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ev_ras_fall,
  input  logic              s_cas_n,
  input  logic              s_we_n,
  input  logic [ADDR_W-1:0] s_addr,
  input  logic [IO_W-1:0]   s_dq,
  input  logic              col_go,
  input  logic              test_mode,
  output logic              req_valid,
  input  logic              req_ready,
  output logic              req_we,
  output logic [GA_W-1:0]   req_addr,
  output logic [SLOTS-1:0]  req_wmask,
  output logic [WD_W-1:0]   req_wdata,
  output logic              ctx_test,
  output logic [SLOT_W-1:0] ctx_slot
);
  logic [ADDR_W-1:0] row_q;
  logic [SLOTS-1:0]  nxt_mask;
  logic [WD_W-1:0]   nxt_wdata;
  logic [SLOT_W-1:0] col_slot;
  logic              load;

  assign col_slot = s_addr[SLOT_W-1:0];

  // per-slot enable and data fan-out
  for (genvar k = 0; k < SLOTS; k++) begin : g_slot
    assign nxt_mask[k] = ~s_we_n & (test_mode | (col_slot == SLOT_W'(k)));
    assign nxt_wdata[k*IO_W +: IO_W] = s_dq;
  end

  assign load = col_go & (~req_valid | req_ready);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      row_q <= '0;
    end else if (ev_ras_fall && s_cas_n) begin
      row_q <= s_addr;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      req_valid <= 1'b0;
      req_we    <= 1'b0;
      req_addr  <= '0;
      req_wmask <= '0;
      req_wdata <= '0;
      ctx_test  <= 1'b0;
      ctx_slot  <= '0;
    end else if (load) begin
      req_valid <= 1'b1;
      req_we    <= ~s_we_n;
      req_addr  <= {row_q, s_addr[ADDR_W-1:SLOT_W]};
      req_wmask <= nxt_mask;
      req_wdata <= nxt_wdata;
      if (s_we_n) begin
        ctx_test <= test_mode;
        ctx_slot <= col_slot;
      end
    end else if (req_ready) begin
      req_valid <= 1'b0;
    end
  end
endmodule

// File: rtl/ptm_compress.sv
module ptm_compress
  import ptm_pkg::*;
#(
  parameter int IO_W     = 4,
  parameter int TM_EXTRA = 2,
  localparam int WD_W    = SLOTS * IO_W,
  localparam int CNT_W   = $clog2(TM_EXTRA + 2)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rsp_valid,
  input  logic [WD_W-1:0]   rsp_data,
  input  logic              ctx_test,
  input  logic [SLOT_W-1:0] ctx_slot,
  output logic              rd_valid,
  output logic [IO_W-1:0]   rd_data
);
  logic [IO_W-1:0]  agree;
  logic [IO_W-1:0]  picked;
  logic [IO_W-1:0]  result;
  logic [CNT_W-1:0] wait_cnt;

  // per I/O line: pass when all four cells carry the same bit
  for (genvar io = 0; io < IO_W; io++) begin : g_line
    logic [SLOTS-1:0] cells;
    for (genvar s = 0; s < SLOTS; s++) begin : g_cell
      assign cells[s] = rsp_data[s*IO_W + io];
    end
    assign agree[io] = (&cells) | ~(|cells);
  end

  assign picked = rsp_data[ctx_slot*IO_W +: IO_W];
  assign result = ctx_test ? agree : picked;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd_valid <= 1'b0;
      rd_data  <= '0;
      wait_cnt <= '0;
    end else if (rsp_valid) begin
      rd_data <= result;
      if (ctx_test && (TM_EXTRA > 0)) begin
        wait_cnt <= CNT_W'(TM_EXTRA);
        rd_valid <= 1'b0;
      end else begin
        rd_valid <= 1'b1;
      end
    end else if (wait_cnt != '0) begin
      wait_cnt <= wait_cnt - 1'b1;
      rd_valid <= (wait_cnt == CNT_W'(1));
    end else begin
      rd_valid <= 1'b0;
    end
  end
endmodule

// File: rtl/ptm_ctrl.sv
module ptm_ctrl
  import ptm_pkg::*;
#(
  parameter int ADDR_W   = 11,
  parameter int IO_W     = 4,
  parameter int TM_EXTRA = 2,
  localparam int GA_W    = 2 * ADDR_W - SLOT_W,
  localparam int WD_W    = SLOTS * IO_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ras_n,
  input  logic              cas_n,
  input  logic              we_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic [IO_W-1:0]   dq_in,
  output logic              rd_valid,
  output logic [IO_W-1:0]   rd_data,
  output logic              test_mode,
  output logic [1:0]        cycle_kind,
  output logic              arr_req_valid,
  input  logic              arr_req_ready,
  output logic              arr_req_we,
  output logic [GA_W-1:0]   arr_req_addr,
  output logic [SLOTS-1:0]  arr_req_wmask,
  output logic [WD_W-1:0]   arr_req_wdata,
  input  logic              arr_rsp_valid,
  input  logic [WD_W-1:0]   arr_rsp_data
);
  logic              s_ras_n, s_cas_n, s_we_n;
  logic [ADDR_W-1:0] s_addr;
  logic [IO_W-1:0]   s_dq;
  logic              ev_ras_fall, ev_ras_rise, ev_cas_fall;
  logic              col_go;
  cyc_kind_e         kind;
  logic              ctx_test;
  logic [SLOT_W-1:0] ctx_slot;

  ptm_strobe_sync #(.ADDR_W(ADDR_W), .IO_W(IO_W)) u_sync (
    .clk(clk), .rst_n(rst_n),
    .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n), .addr(addr), .dq_in(dq_in),
    .s_ras_n(s_ras_n), .s_cas_n(s_cas_n), .s_we_n(s_we_n),
    .s_addr(s_addr), .s_dq(s_dq),
    .ev_ras_fall(ev_ras_fall), .ev_ras_rise(ev_ras_rise), .ev_cas_fall(ev_cas_fall)
  );

  ptm_mode_fsm u_fsm (
    .clk(clk), .rst_n(rst_n),
    .ev_ras_fall(ev_ras_fall), .ev_ras_rise(ev_ras_rise), .ev_cas_fall(ev_cas_fall),
    .s_ras_n(s_ras_n), .s_cas_n(s_cas_n), .s_we_n(s_we_n),
    .test_mode(test_mode), .kind(kind), .col_go(col_go)
  );

  ptm_access #(.ADDR_W(ADDR_W), .IO_W(IO_W)) u_acc (
    .clk(clk), .rst_n(rst_n),
    .ev_ras_fall(ev_ras_fall), .s_cas_n(s_cas_n), .s_we_n(s_we_n),
    .s_addr(s_addr), .s_dq(s_dq), .col_go(col_go), .test_mode(test_mode),
    .req_valid(arr_req_valid), .req_ready(arr_req_ready), .req_we(arr_req_we),
    .req_addr(arr_req_addr), .req_wmask(arr_req_wmask), .req_wdata(arr_req_wdata),
    .ctx_test(ctx_test), .ctx_slot(ctx_slot)
  );

  ptm_compress #(.IO_W(IO_W), .TM_EXTRA(TM_EXTRA)) u_cmp (
    .clk(clk), .rst_n(rst_n),
    .rsp_valid(arr_rsp_valid), .rsp_data(arr_rsp_data),
    .ctx_test(ctx_test), .ctx_slot(ctx_slot),
    .rd_valid(rd_valid), .rd_data(rd_data)
  );

  assign cycle_kind = kind;
endmodule

// File: rtl/ptm_ctrl_chk.sv
module ptm_ctrl_chk #(
  parameter int GA_W = 20
) (
  input logic            clk,
  input logic            rst_n,
  input logic            ev_ras_fall,
  input logic            s_cas_n,
  input logic            s_we_n,
  input logic            test_mode,
  input logic [1:0]      cycle_kind,
  input logic            rd_valid,
  input logic            arr_req_valid,
  input logic            arr_req_ready,
  input logic            arr_req_we,
  input logic [GA_W-1:0] arr_req_addr,
  input logic [3:0]      arr_req_wmask
);
  assert_reset_idle_R1: assert property (@(posedge clk)
    $rose(rst_n) |-> (!test_mode && !arr_req_valid && !rd_valid && cycle_kind == 2'd0));

  assert_wcbr_enter_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_ras_fall && !s_cas_n && !s_we_n) |=> test_mode);

  assert_cbr_exit_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_ras_fall && !s_cas_n && s_we_n) |=> !test_mode);

  // R7 and R6: a write enables either a single cell or the whole group
  assert_wmask_shape_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (arr_req_valid && arr_req_we) |-> ($countones(arr_req_wmask) == 1 || arr_req_wmask == 4'hF));

  assert_read_no_mask_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (arr_req_valid && !arr_req_we) |-> (arr_req_wmask == 4'h0));

  assert_rd_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |=> !rd_valid);

  assert_req_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (arr_req_valid && !arr_req_ready) |=>
      (arr_req_valid && $stable(arr_req_addr) && $stable(arr_req_wmask) && $stable(arr_req_we)));

  assert_kind_row_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_ras_fall && s_cas_n) |=> (cycle_kind == 2'd1));
endmodule

bind ptm_ctrl ptm_ctrl_chk #(.GA_W(GA_W)) u_chk (
  .clk(clk), .rst_n(rst_n),
  .ev_ras_fall(ev_ras_fall), .s_cas_n(s_cas_n), .s_we_n(s_we_n),
  .test_mode(test_mode), .cycle_kind(cycle_kind), .rd_valid(rd_valid),
  .arr_req_valid(arr_req_valid), .arr_req_ready(arr_req_ready),
  .arr_req_we(arr_req_we), .arr_req_addr(arr_req_addr),
  .arr_req_wmask(arr_req_wmask)
);

// File: tb/tb_ptm_ctrl.sv
`timescale 1ns/1ps
module tb_ptm_ctrl;
  localparam int ADDR_W   = 3;
  localparam int IO_W     = 4;
  localparam int TM_EXTRA = 2;
  localparam int GA_W     = 2 * ADDR_W - 2;
  localparam int WD_W     = 4 * IO_W;
  localparam int GROUPS   = 1 << GA_W;

  localparam logic [2:0] OP_WR = 3'd0, OP_RD = 3'd1, OP_WCBR = 3'd2,
                         OP_CBR = 3'd3, OP_RONLY = 3'd4;

  typedef struct packed {
    logic [2:0] op;
    logic [2:0] row;
    logic [2:0] col;
    logic [3:0] din;
    logic [3:0] exp_dat;
    logic       exp_mode;
  } vec_t;

  localparam int NVEC = 21;
  localparam vec_t VEC [NVEC] = '{
    '{OP_WR,    3'd1, 3'd0, 4'hA, 4'h0, 1'b0},
    '{OP_WR,    3'd1, 3'd1, 4'h5, 4'h0, 1'b0},
    '{OP_RD,    3'd1, 3'd0, 4'h0, 4'hA, 1'b0},
    '{OP_RD,    3'd1, 3'd1, 4'h0, 4'h5, 1'b0},
    '{OP_RD,    3'd1, 3'd2, 4'h0, 4'h0, 1'b0},
    '{OP_WCBR,  3'd0, 3'd0, 4'h0, 4'h0, 1'b1},
    '{OP_WR,    3'd2, 3'd0, 4'h6, 4'h0, 1'b1},
    '{OP_RD,    3'd2, 3'd3, 4'h0, 4'hF, 1'b1},
    '{OP_WR,    3'd1, 3'd0, 4'h0, 4'h0, 1'b1},
    '{OP_CBR,   3'd0, 3'd0, 4'h0, 4'h0, 1'b0},
    '{OP_RD,    3'd2, 3'd2, 4'h0, 4'h6, 1'b0},
    '{OP_WR,    3'd2, 3'd1, 4'hF, 4'h0, 1'b0},
    '{OP_WCBR,  3'd0, 3'd0, 4'h0, 4'h0, 1'b1},
    '{OP_RD,    3'd2, 3'd2, 4'h0, 4'h6, 1'b1},
    '{OP_RD,    3'd1, 3'd1, 4'h0, 4'hF, 1'b1},
    '{OP_WCBR,  3'd0, 3'd0, 4'h0, 4'h0, 1'b1},
    '{OP_RD,    3'd2, 3'd0, 4'h0, 4'h6, 1'b1},
    '{OP_RONLY, 3'd5, 3'd0, 4'h0, 4'h0, 1'b0},
    '{OP_RD,    3'd2, 3'd1, 4'h0, 4'hF, 1'b0},
    '{OP_RD,    3'd2, 3'd0, 4'h0, 4'h6, 1'b0},
    '{OP_RD,    3'd1, 3'd1, 4'h0, 4'h0, 1'b0}
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ras_n = 1'b1, cas_n = 1'b1, we_n = 1'b1;
  logic [ADDR_W-1:0] addr = '0;
  logic [IO_W-1:0] dq_in = '0;
  logic rd_valid, test_mode;
  logic [IO_W-1:0] rd_data;
  logic [1:0] cycle_kind;
  logic arr_req_valid, arr_req_we;
  logic arr_req_ready;
  logic [GA_W-1:0] arr_req_addr;
  logic [3:0] arr_req_wmask;
  logic [WD_W-1:0] arr_req_wdata;
  logic arr_rsp_valid;
  logic [WD_W-1:0] arr_rsp_data;
  logic mdl_ready = 1'b1;
  logic [WD_W-1:0] mem [GROUPS];

  int n_vec = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  ptm_ctrl #(.ADDR_W(ADDR_W), .IO_W(IO_W), .TM_EXTRA(TM_EXTRA)) dut (
    .clk(clk), .rst_n(rst_n), .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n),
    .addr(addr), .dq_in(dq_in), .rd_valid(rd_valid), .rd_data(rd_data),
    .test_mode(test_mode), .cycle_kind(cycle_kind),
    .arr_req_valid(arr_req_valid), .arr_req_ready(arr_req_ready),
    .arr_req_we(arr_req_we), .arr_req_addr(arr_req_addr),
    .arr_req_wmask(arr_req_wmask), .arr_req_wdata(arr_req_wdata),
    .arr_rsp_valid(arr_rsp_valid), .arr_rsp_data(arr_rsp_data)
  );

  // behavioural cell array: four cells of IO_W bits per group
  assign arr_req_ready = mdl_ready;
  always @(posedge clk) begin
    if (!rst_n) begin
      arr_rsp_valid <= 1'b0;
      arr_rsp_data  <= '0;
    end else begin
      arr_rsp_valid <= 1'b0;
      if (arr_req_valid && arr_req_ready) begin
        if (arr_req_we) begin
          for (int k = 0; k < 4; k++)
            if (arr_req_wmask[k])
              mem[arr_req_addr][k*IO_W +: IO_W] <= arr_req_wdata[k*IO_W +: IO_W];
        end else begin
          arr_rsp_valid <= 1'b1;
          arr_rsp_data  <= mem[arr_req_addr];
        end
      end
    end
  end

  task automatic check(input string req, input int act, input int exp);
    n_vec++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic refresh_cycle(input logic wbit);
    @(negedge clk);
    cas_n = 1'b0; we_n = wbit;
    idle(2);
    ras_n = 1'b0;
    idle(3);
    ras_n = 1'b1; cas_n = 1'b1; we_n = 1'b1;
    idle(3);
  endtask

  task automatic ras_only(input logic [ADDR_W-1:0] row);
    @(negedge clk);
    addr = row; ras_n = 1'b0;
    idle(4);
    ras_n = 1'b1;
    idle(3);
  endtask

  // one row cycle with one column access; reports read data and latency
  task automatic access(input logic wr, input logic [ADDR_W-1:0] row,
                        input logic [ADDR_W-1:0] col, input logic [IO_W-1:0] d,
                        output logic [IO_W-1:0] q, output int lat, output bit got);
    int t_rsp;
    q = '0; lat = -1; got = 1'b0; t_rsp = -1;
    @(negedge clk);
    addr = row; ras_n = 1'b0;
    idle(3);
    addr = col; we_n = ~wr; dq_in = d; cas_n = 1'b0;
    if (wr) begin
      idle(4);
    end else begin
      for (int c = 0; c < 40 && !got; c++) begin
        @(negedge clk);
        if (arr_rsp_valid) t_rsp = c;
        if (rd_valid) begin
          got = 1'b1; q = rd_data; lat = c - t_rsp;
        end
      end
    end
    cas_n = 1'b1; we_n = 1'b1;
    idle(2);
    ras_n = 1'b1;
    idle(3);
  endtask

  function automatic int kind_of(input logic [2:0] op);
    if (op == OP_WCBR) return 3;
    if (op == OP_CBR) return 2;
    return 1;
  endfunction

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_bad++;
      n_vec++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin
    logic [IO_W-1:0] q;
    int lat;
    bit got;
    for (int g = 0; g < GROUPS; g++) mem[g] = '0;
    idle(3);
    // R1: reset state
    check("R1 test_mode", int'(test_mode), 0);
    check("R1 cycle_kind", int'(cycle_kind), 0);
    check("R1 req_valid", int'(arr_req_valid), 0);
    check("R1 rd_valid", int'(rd_valid), 0);
    @(negedge clk); rst_n = 1'b1;
    idle(2);

    // vector walk: R2 R3 R4 R5 R6 R7 R8 R9 R12 R13
    for (int i = 0; i < NVEC; i++) begin
      case (VEC[i].op)
        OP_WCBR:  refresh_cycle(1'b0);
        OP_CBR:   refresh_cycle(1'b1);
        OP_RONLY: ras_only(VEC[i].row);
        OP_WR:    access(1'b1, VEC[i].row, VEC[i].col, VEC[i].din, q, lat, got);
        default: begin
          access(1'b0, VEC[i].row, VEC[i].col, 4'h0, q, lat, got);
          check($sformatf("R8/R9 read data vec %0d", i), got ? int'(q) : -1,
                int'(VEC[i].exp_dat));
        end
      endcase
      check($sformatf("R2/R3/R4/R5 mode vec %0d", i), int'(test_mode), int'(VEC[i].exp_mode));
      check($sformatf("R12 kind vec %0d", i), int'(cycle_kind), kind_of(VEC[i].op));
    end

    // R10 normal latency and R8 data
    access(1'b1, 3'd3, 3'd4, 4'h9, q, lat, got);
    access(1'b0, 3'd3, 3'd4, 4'h0, q, lat, got);
    check("R8 normal data", int'(q), 9);
    check("R10 normal latency", lat, 1);

    // R10 test latency, R9 per-line compare, R13 ignores col[1:0]
    refresh_cycle(1'b0);
    access(1'b0, 3'd3, 3'd6, 4'h0, q, lat, got);
    check("R9 test compare", int'(q), 6);
    check("R10 test latency", lat, 1 + TM_EXTRA);
    ras_only(3'd0);
    check("R4 ras-only exit", int'(test_mode), 0);

    // R11 back-pressure hold, R6 single-cell mask, R13 group address
    mdl_ready = 1'b0;
    access(1'b1, 3'd4, 3'd6, 4'hC, q, lat, got);
    check("R11 held valid", int'(arr_req_valid), 1);
    check("R13 group address", int'(arr_req_addr), (4 << 1) | 1);
    check("R6 single mask", int'(arr_req_wmask), 4'b0100);
    idle(3);
    check("R11 still held", int'(arr_req_valid), 1);
    check("R11 addr stable", int'(arr_req_addr), (4 << 1) | 1);
    mdl_ready = 1'b1;
    idle(2);
    check("R11 released", int'(arr_req_valid), 0);
    access(1'b0, 3'd4, 3'd6, 4'h0, q, lat, got);
    check("R11 write landed", int'(q), 12);
    access(1'b0, 3'd4, 3'd7, 4'h0, q, lat, got);
    check("R6 neighbour untouched", int'(q), 0);

    // R1: reset from test mode
    refresh_cycle(1'b0);
    check("R2 entered before reset", int'(test_mode), 1);
    @(negedge clk); rst_n = 1'b0;
    idle(2);
    check("R1 reset clears mode", int'(test_mode), 0);
    check("R1 reset clears kind", int'(cycle_kind), 0);
    @(negedge clk); rst_n = 1'b1;
    idle(2);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule